// File: doc/BRIEF.md
# MDIO Management Interface Controller

This block is a host-programmed master for the two-wire PHY management interface. It runs one read or one write of a PHY register at a time. The host sees two 16-bit words. The control word holds the PHY address, the register address, a direction select and a completion flag. The data word holds the value to send, or the value that came back from the PHY. A host write to the control word while the block is idle starts a transaction. While a transaction runs, further writes to the control word are dropped, so the fields cannot change under the running frame.

On the PHY side the block generates the management clock from the system clock by an even division ratio. It drives the shared data line through separate output, output-enable and input signals. A frame goes out as 32 preamble ones, start bits `01`, a two-bit opcode, five PHY address bits, five register address bits, a two-bit turnaround and sixteen data bits. Output data changes on the falling edge of the management clock. Read data is sampled on the rising edge.

The sequencer is an enumerated state machine with these states:
- `ST_IDLE`: the clock is parked low and the line is released.
- `ST_PRE`: frame bits 0 to 31.
- `ST_HDR`: frame bits 32 to 45.
- `ST_TA`: frame bits 46 and 47.
- `ST_DATA`: frame bits 48 to 63.
- `ST_FINISH`: one cycle that reports completion.

Its transitions are:
- `IDLE->PRE` on a start.
- `PRE->HDR` at the falling clock edge that ends bit 31.
- `HDR->TA` at the falling edge that ends bit 45.
- `TA->DATA` at the falling edge that ends bit 47.
- `DATA->FINISH` at the falling edge that ends bit 63.
- `FINISH->IDLE` unconditionally.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word and the data word both read 0x0000. The management clock is low and the line is released.
- R2: Control word layout: bit 15 is the done flag, bit 14 is the direction (1 = write, 0 = read), bits 12:8 are the PHY address and bits 4:0 are the register address. Bits 13 and 7:5 always read as zero. Host select 0 addresses the control word and select 1 addresses the data word.
- R3: The done flag reads 0 while a transaction is in progress and reads 1 once it has completed.
- R4: A host write to the control word while a transaction is in progress is ignored, and all fields keep their values.
- R5: A host write to the control word while idle loads the fields and starts a transaction. On the next clock the block is busy and the done flag is 0.
- R6: Every frame begins with 32 ones, then `01`, then opcode `01` for a write or `10` for a read.
- R7: After the opcode come the PHY address and then the register address, each sent MSB first (control bit 12 first, then control bit 4 first).
- R8: On a write the master drives the turnaround as `1` then `0`. It then sends the data word MSB first, keeping the line driven for all 64 bits.
- R9: On a read the master releases the line during both turnaround bits and all 16 data bits.
- R10: On a read the 16 bits sampled on rising management clock edges are loaded MSB first into the data word when the transaction completes.
- R11: The management clock has a period of DIV system clocks, high and low for DIV/2 each. It toggles only during a transaction. When idle it is low and the line is released.
- R12: While the line stays driven, the output data changes only in the cycle where the management clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Word select: 0 control, 1 data |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected word, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Writes are exercised with two address and data patterns of opposite bit parity. This separates a reversed or swapped bit order from a correct one in the address and data fields. Reads return one mixed pattern and one pattern with only the end bits set, which exposes an off-by-one in the sampling point or the shift direction. The control word is written with its reserved bits set, both while idle and mid-frame, to tell correct field masking apart from a dropped or a leaked write. The measured clock period and the edge on which data changes distinguish the divider and launch timing from an early or late edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Frame geometry (bit index counted from the first preamble bit)
    localparam int FRAME_BITS = 64;
    localparam int HDR_FIRST  = 32;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int LAST_BIT   = FRAME_BITS - 1;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam int ADDR_W = 5;
    localparam int WORD_W = 16;

    // Control word positions
    localparam int CTL_DONE  = 15;
    localparam int CTL_WRITE = 14;
    localparam int CTL_PHY_LO = 8;
    localparam int CTL_REG_LO = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_FINISH
    } mdio_state_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
    } mdio_cmd_t;

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_en,
    output logic fall_en
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    assign tick    = run && (cnt_q == CW'(HALF - 1));
    assign rise_en = tick && !mdc_q;
    assign fall_en = tick && mdc_q;
    assign mdc     = mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rise_en,
    input  logic              fall_en,
    input  logic              mdio_i,
    output logic              busy,
    output logic              clk_run,
    output logic              done_pulse,
    output logic [WORD_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    mdio_state_t       state_q;
    logic [IDX_W-1:0]  bit_q;
    mdio_cmd_t         cmd_q;
    logic [WORD_W-1:0] wdat_q;
    logic [WORD_W-1:0] rsh_q;

    logic [13:0]      hdr_bits;
    logic [IDX_W-1:0] hdr_pos;
    logic [3:0]       dat_pos;

    assign hdr_bits = {2'b01, (cmd_q.wr ? 2'b01 : 2'b10), cmd_q.phy, cmd_q.regad};
    assign hdr_pos  = IDX_W'(TA_FIRST - 1) - bit_q;
    assign dat_pos  = 4'd15 - bit_q[3:0];

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            cmd_q   <= '0;
            wdat_q  <= '0;
            rsh_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_PRE;
                        bit_q   <= '0;
                        cmd_q   <= cmd;
                        wdat_q  <= wdata;
                    end
                end
                ST_PRE, ST_HDR, ST_TA, ST_DATA: begin
                    if (rise_en && state_q == ST_DATA && !cmd_q.wr)
                        rsh_q <= {rsh_q[WORD_W-2:0], mdio_i};
                    if (fall_en) begin
                        if (bit_q == IDX_W'(LAST_BIT)) begin
                            state_q <= ST_FINISH;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            if (bit_q == IDX_W'(HDR_FIRST - 1))  state_q <= ST_HDR;
                            if (bit_q == IDX_W'(TA_FIRST - 1))   state_q <= ST_TA;
                            if (bit_q == IDX_W'(DATA_FIRST - 1)) state_q <= ST_DATA;
                        end
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        mdio_o     = 1'b0;
        mdio_oe    = 1'b0;
        busy       = 1'b1;
        clk_run    = 1'b1;
        done_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                clk_run = 1'b0;
            end
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HDR: begin
                mdio_o  = hdr_bits[hdr_pos[3:0]];
                mdio_oe = 1'b1;
            end
            ST_TA: begin
                mdio_o  = cmd_q.wr && (bit_q == IDX_W'(TA_FIRST));
                mdio_oe = cmd_q.wr;
            end
            ST_DATA: begin
                mdio_o  = cmd_q.wr && wdat_q[dat_pos];
                mdio_oe = cmd_q.wr;
            end
            ST_FINISH: begin
                clk_run    = 1'b0;
                done_pulse = 1'b1;
            end
            default: begin
                busy    = 1'b0;
                clk_run = 1'b0;
            end
        endcase
    end

    assign rdata = rsh_q;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              seq_busy,
    input  logic              seq_done,
    input  logic [WORD_W-1:0] seq_rdata,
    output logic              start,
    output logic              xfer_busy,
    output mdio_cmd_t         cmd,
    output logic [WORD_W-1:0] dat_word,
    output logic [WORD_W-1:0] ctl_word
);
    mdio_cmd_t         cmd_q;
    logic              done_q;
    logic              start_q;
    logic [WORD_W-1:0] dat_q;
    logic              ctl_wr;

    assign xfer_busy = start_q || seq_busy;
    assign ctl_wr    = host_wr && !host_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            done_q  <= 1'b0;
            start_q <= 1'b0;
            dat_q   <= '0;
        end else begin
            start_q <= 1'b0;
            if (ctl_wr && !xfer_busy) begin
                cmd_q.wr    <= host_wdata[CTL_WRITE];
                cmd_q.phy   <= host_wdata[CTL_PHY_LO +: ADDR_W];
                cmd_q.regad <= host_wdata[CTL_REG_LO +: ADDR_W];
                done_q      <= 1'b0;
                start_q     <= 1'b1;
            end
            if (host_wr && host_sel)
                dat_q <= host_wdata;
            if (seq_done) begin
                done_q <= 1'b1;
                if (!cmd_q.wr)
                    dat_q <= seq_rdata;
            end
        end
    end

    assign start    = start_q;
    assign cmd      = cmd_q;
    assign dat_word = dat_q;
    assign ctl_word = {done_q, cmd_q.wr, 1'b0, cmd_q.phy, 3'b000, cmd_q.regad};
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start;
    logic              xfer_busy;
    logic              seq_busy;
    logic              seq_done;
    logic              clk_run;
    logic              rise_en;
    logic              fall_en;
    mdio_cmd_t         cmd;
    logic [WORD_W-1:0] seq_rdata;
    logic [WORD_W-1:0] dat_word;
    logic [WORD_W-1:0] ctl_word;

    mdio_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .seq_busy   (seq_busy),
        .seq_done   (seq_done),
        .seq_rdata  (seq_rdata),
        .start      (start),
        .xfer_busy  (xfer_busy),
        .cmd        (cmd),
        .dat_word   (dat_word),
        .ctl_word   (ctl_word)
    );

    mdc_divider #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (clk_run),
        .mdc     (mdc),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    mdio_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd        (cmd),
        .wdata      (dat_word),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .mdio_i     (mdio_i),
        .busy       (seq_busy),
        .clk_run    (clk_run),
        .done_pulse (seq_done),
        .rdata      (seq_rdata),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    assign host_rdata = host_sel ? dat_word : ctl_word;
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_sel,
    input logic        xfer_busy,
    input logic [15:0] ctl_word,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R4: control fields frozen against a write while busy
    p_locked_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && xfer_busy) |=> $stable(ctl_word[14:0]));

    // R3: done flag low throughout a transaction
    p_done_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> !ctl_word[15]);

    // R5: idle control write starts a transaction and clears done
    p_idle_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && !xfer_busy) |=> (xfer_busy && !ctl_word[15]));

    // R11: clock parked and line released when idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> (!mdc && !mdio_oe));

    // R11: clock rises only inside a transaction
    p_mdc_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> xfer_busy);

    // R12: driven data changes only where the clock falls
    p_change_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
endmodule

bind mdio_master mdio_master_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_sel  (host_sel),
    .xfer_busy (xfer_busy),
    .ctl_word  (ctl_word),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_master #(.DIV(DIV)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model and line monitor
    logic [63:0] cap_o, cap_oe;
    int          cap_idx = 0;
    int          last_rise = 0;
    int          period_bad = 0;
    int          change_bad = 0;
    logic [15:0] phy_reply = '0;
    logic        prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

    always @(negedge clk) begin
        if (mdc && !prev_mdc) begin
            if (cap_idx > 0 && (cyc - last_rise) != DIV) period_bad++;
            last_rise = cyc;
            if (cap_idx < 64) begin
                cap_o[63 - cap_idx]  = mdio_o;
                cap_oe[63 - cap_idx] = mdio_oe;
            end
            cap_idx++;
        end
        if (!mdc && prev_mdc) begin
            if (cap_idx >= 48 && cap_idx < 64) mdio_i = phy_reply[63 - cap_idx];
            else mdio_i = 1'b1;
        end
        if (mdio_oe && prev_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc)) change_bad++;
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [15:0] d);
        host_sel = sel;
        #0.5;
        d = host_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [15:0] v;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            host_read(1'b0, v);
            if (v[15]) break;
        end
        chk(req, {63'd0, v[15]}, 64'd1);
    endtask

    // Transaction scenario: expected frame built from the requirements
    task automatic run_xfer(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [15:0] reply, input bit poke);
        logic [15:0] v, exp_ctl;
        logic [63:0] exp_frame;
        exp_ctl = {1'b0, wr, 1'b0, phy, 3'b000, rg};
        exp_frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, wd};
        phy_reply = reply;
        if (wr) host_write(1'b1, wd);
        cap_idx = 0; period_bad = 0; change_bad = 0;
        // reserved bits 13, 7:5 and done bit set in the write value
        host_write(1'b0, exp_ctl | 16'hA0E0);
        host_read(1'b0, v);
        chk("R5/R2 ctl after start", {48'd0, v}, {48'd0, exp_ctl});
        if (poke) begin
            repeat (40) @(negedge clk);
            host_write(1'b0, ~exp_ctl);
            host_read(1'b0, v);
            chk("R4 write ignored while busy", {48'd0, v}, {48'd0, exp_ctl});
            chk("R3 done low while busy", {63'd0, v[15]}, 64'd0);
        end
        wait_done("R3 done set");
        host_read(1'b0, v);
        chk("R3 ctl after done", {48'd0, v}, {48'd0, exp_ctl | 16'h8000});
        chk("R11 frame length", cap_idx, 64);
        chk("R6 preamble/start/opcode", cap_o[63:28], exp_frame[63:28]);
        chk("R7 address bits", cap_o[27:18], exp_frame[27:18]);
        if (wr) begin
            chk("R8 turnaround and data", cap_o[17:0], exp_frame[17:0]);
            chk("R8 line driven all frame", cap_oe, {64{1'b1}});
        end else begin
            chk("R9 driven through header", cap_oe[63:18], {46{1'b1}});
            chk("R9 released at TA and data", cap_oe[17:0], 64'd0);
            host_read(1'b1, v);
            chk("R10 read data word", {48'd0, v}, {48'd0, reply});
        end
        chk("R11 mdc period", period_bad, 0);
        chk("R11 idle quiet", {62'd0, mdc, mdio_oe}, 64'd0);
        chk("R12 change on falling edge", change_bad, 0);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        host_read(1'b0, v);
        chk("R1 ctl reset", {48'd0, v}, 64'd0);
        host_read(1'b1, v);
        chk("R1 data reset", {48'd0, v}, 64'd0);
        chk("R1 mdc/oe reset", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_xfer(1'b1, 5'h13, 5'h0A, 16'hA5C3, 16'h0000, 1'b1);
        run_xfer(1'b0, 5'h05, 5'h11, 16'h0000, 16'h3C96, 1'b1);
        run_xfer(1'b1, 5'h0C, 5'h15, 16'h5A3C, 16'h0000, 1'b0);
        run_xfer(1'b0, 5'h1F, 5'h00, 16'h0000, 16'h8001, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule